// File: doc/BRIEF.md
# GPIO Interrupt Edge Detector with Filter

This block is the interrupt front end for a bank of general-purpose input lines (at most 24). Each line is first passed through a synchronizer. It can then go through a per-line glitch filter that accepts a new level only after the level has been steady for a programmable number of clocks. The block drives one request per line toward a parent interrupt controller.

A line works in one of two ways:

- **Level mode:** the request follows the line's level, gated by the line's enable bit.
- **Both-edge mode:** every accepted level change, rising or falling, is reported as a single-clock active-low pulse. This gives the parent a falling edge to detect.

Both-edge detection works only through the glitch filter. If the mode bit is set while the filter bit is clear, the line stays quiet. The filter period is held in one register and is shared by all lines. The filter acts only on the interrupt path; the plain data path of the lines is never filtered.

Software programs four registers at fixed byte offsets: line enable, mode, filter enable and filter period.

Each line's filter is a two-state machine:

- **HOLD:** the synchronized input equals the accepted level.
- **COUNT:** a different level is being timed.

Its transitions are:

- **HOLD→COUNT (start):** the input differs from the accepted level and the period is 2 or more.
- **HOLD→HOLD (instant accept):** the input differs and the period is 0 or 1.
- **COUNT→COUNT (tick):** the input still differs and the period is not yet reached.
- **COUNT→HOLD (accept):** the input has differed for the full period.
- **COUNT→HOLD (discard):** the input returns to the accepted level before the period is reached.
- **Any→HOLD (bypass):** the filter is disabled; the accepted level then tracks the input.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset the enable, mode and filter-enable registers read 0, the filter period reads 0xFF, and every request output is 0.
- R2: Register offsets are fixed: enable at 0x90, mode at 0x94 and filter enable at 0x98, each using bits [NUM_LINES-1:0] with bit i for line i. The period is at 0x9C in bits [PERIOD_W-1:0]. Unused bits read 0. Other addresses read 0, and writes to them change nothing.
- R3: In level mode (mode bit 0) with the filter off, the request equals the line input ANDed with the enable bit. It appears on the third rising clock edge after the input changes: two synchronizer stages plus the output register.
- R4: In level mode, a cleared enable bit forces the line's request to 0.
- R5: With the filter on, a new level is accepted only after the synchronized input has differed from the accepted level on P consecutive clock edges, where P is the period and P=0 acts as 1. Shorter excursions are discarded and produce no pulse.
- R6: In both-edge mode, with filter and enable set, each accepted change drives the request low for exactly one clock; otherwise the request is 1. For an input held for at least P clocks, the first low sample follows the (2+P)-th rising edge after the change, and the return to the old level gives a second pulse.
- R7: In both-edge mode with the filter off, the request stays 1 whatever the input does.
- R8: In both-edge mode with the enable bit clear, the request stays 1.
- R9: Activity on one line never changes the request of another line.
- R10: In level mode with the filter on, the request follows the filtered level, so a glitch shorter than P leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| line_in | input | NUM_LINES | Asynchronous line inputs |
| irq_out | output | NUM_LINES | Per-line request toward the parent controller |

## Verification
The hardest situation to reach from the ports is an excursion whose length sits exactly at the filter threshold. One cycle shorter must vanish; exactly P must yield two pulses, and with P=1 those pulses are back to back. The bench sweeps the period over 0 to 4 and, for each period, holds the input away for every length from 1 to P+1 clocks. It counts the low cycles and finds the first one arithmetically from P and the hold length. During each trial it also watches the other lines, which are kept in the same mode, and checks that they stay idle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam logic [7:0] OFS_ENABLE = 8'h90;
    localparam logic [7:0] OFS_MODE   = 8'h94;
    localparam logic [7:0] OFS_FLTEN  = 8'h98;
    localparam logic [7:0] OFS_PERIOD = 8'h9C;
    localparam int         PERIOD_RESET = 255;

    typedef enum logic {
        FLT_HOLD  = 1'b0,
        FLT_COUNT = 1'b1
    } flt_state_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int PERIOD_W  = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [NUM_LINES-1:0] flt_q,
    output logic [PERIOD_W-1:0]  period_q
);
    localparam logic [PERIOD_W-1:0] PERIOD_RST = PERIOD_W'(PERIOD_RESET);

    logic hit_en, hit_mode, hit_flt, hit_per;

    always_comb begin
        hit_en   = (addr == ADDR_W'(OFS_ENABLE));
        hit_mode = (addr == ADDR_W'(OFS_MODE));
        hit_flt  = (addr == ADDR_W'(OFS_FLTEN));
        hit_per  = (addr == ADDR_W'(OFS_PERIOD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            mode_q   <= '0;
            flt_q    <= '0;
            period_q <= PERIOD_RST;
        end else if (wr) begin
            if (hit_en)   en_q     <= wdata[NUM_LINES-1:0];
            if (hit_mode) mode_q   <= wdata[NUM_LINES-1:0];
            if (hit_flt)  flt_q    <= wdata[NUM_LINES-1:0];
            if (hit_per)  period_q <= wdata[PERIOD_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_en)   rdata[NUM_LINES-1:0] = en_q;
        if (hit_mode) rdata[NUM_LINES-1:0] = mode_q;
        if (hit_flt)  rdata[NUM_LINES-1:0] = flt_q;
        if (hit_per)  rdata[PERIOD_W-1:0]  = period_q;
    end
endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                filt_on,
    input  logic [PERIOD_W-1:0] period,
    input  logic                din,
    output logic                level,
    output logic                accept
);
    flt_state_e          state_q, state_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d;
    logic                lvl_q, lvl_d;
    logic [PERIOD_W:0]   cnt_inc;
    logic                reach_first, reach_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        cnt_inc     = {1'b0, cnt_q} + (PERIOD_W+1)'(1);
        reach_first = (period <= PERIOD_W'(1));
        reach_cnt   = (cnt_inc >= {1'b0, period});
        state_d     = state_q;
        cnt_d       = cnt_q;
        lvl_d       = lvl_q;
        accept      = 1'b0;
        if (!filt_on) begin
            state_d = FLT_HOLD;
            cnt_d   = '0;
            lvl_d   = din;
        end else begin
            unique case (state_q)
                FLT_HOLD: begin
                    if (din != lvl_q) begin
                        if (reach_first) begin
                            accept = 1'b1;
                            lvl_d  = din;
                        end else begin
                            state_d = FLT_COUNT;
                            cnt_d   = PERIOD_W'(1);
                        end
                    end
                end
                FLT_COUNT: begin
                    if (din == lvl_q) begin
                        state_d = FLT_HOLD;
                        cnt_d   = '0;
                    end else if (reach_cnt) begin
                        accept  = 1'b1;
                        lvl_d   = din;
                        state_d = FLT_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[PERIOD_W-1:0];
                    end
                end
            endcase
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/gpio_irq_outstage.sv
module gpio_irq_outstage #(
    parameter int NUM_LINES = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] mode,
    input  logic [NUM_LINES-1:0] flt,
    input  logic [NUM_LINES-1:0] sync_lvl,
    input  logic [NUM_LINES-1:0] filt_lvl,
    input  logic [NUM_LINES-1:0] filt_acc,
    output logic [NUM_LINES-1:0] irq
);
    logic [NUM_LINES-1:0] edge_hit, lvl_sel, irq_d;

    always_comb begin
        edge_hit = en & flt & filt_acc;
        lvl_sel  = (flt & filt_lvl) | (~flt & sync_lvl);
        irq_d    = (mode & ~edge_hit) | (~mode & en & lvl_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= '0;
        else        irq <= irq_d;
    end
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front #(
    parameter int NUM_LINES   = 24,
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] en_q, mode_q, flt_q;
    logic [PERIOD_W-1:0]  period_q;
    logic [NUM_LINES-1:0] sync_s, flt_lvl, flt_acc;

    gpio_irq_regs #(
        .NUM_LINES(NUM_LINES), .PERIOD_W(PERIOD_W), .ADDR_W(8), .DATA_W(32)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en_q(en_q), .mode_q(mode_q),
        .flt_q(flt_q), .period_q(period_q)
    );

    gpio_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(sync_s)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gpio_irq_filter #(.PERIOD_W(PERIOD_W)) u_filt (
            .clk(clk), .rst_n(rst_n), .filt_on(flt_q[i]), .period(period_q),
            .din(sync_s[i]), .level(flt_lvl[i]), .accept(flt_acc[i])
        );
    end

    gpio_irq_outstage #(.NUM_LINES(NUM_LINES)) u_out (
        .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .flt(flt_q),
        .sync_lvl(sync_s), .filt_lvl(flt_lvl), .filt_acc(flt_acc), .irq(irq_out)
    );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NUM_LINES = 24,
    parameter int PERIOD_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] en,
    input logic [NUM_LINES-1:0] mode,
    input logic [NUM_LINES-1:0] flt,
    input logic [PERIOD_W-1:0]  period,
    input logic [NUM_LINES-1:0] sync_s,
    input logic [NUM_LINES-1:0] lvl,
    input logic [NUM_LINES-1:0] acc,
    input logic [NUM_LINES-1:0] irq
);
    assert_period_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (period == PERIOD_W'(255)));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        assert_level_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !mode[i]) |=> !irq[i]);
        assert_accept_takes_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (flt[i] && acc[i]) |=> (lvl[i] == $past(sync_s[i])));
        assert_hold_without_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (flt[i] && !acc[i]) |=> $stable(lvl[i]));
        assert_edge_pulse_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && mode[i] && flt[i] && acc[i]) |=> !irq[i]);
        assert_edge_nofilter_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] && !flt[i]) |=> irq[i]);
        assert_edge_masked_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[i] && !en[i]) |=> irq[i]);
    end
endmodule

bind gpio_irq_front gpio_irq_chk #(.NUM_LINES(NUM_LINES), .PERIOD_W(PERIOD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .flt(flt_q),
    .period(period_q), .sync_s(sync_s), .lvl(flt_lvl), .acc(flt_acc), .irq(irq_out)
);

// File: tb/tb_gpio_irq_front.sv
module tb_gpio_irq_front;
    localparam int N  = 4;
    localparam int PW = 8;

    logic          clk, rst_n, reg_wr;
    logic [7:0]    reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic [N-1:0]  line_in, irq_out;
    int            total, bad;

    gpio_irq_front #(.NUM_LINES(N), .PERIOD_W(PW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
        .irq_out(irq_out)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [7:0] a, input int exp, input string req);
        reg_addr = a;
        #1;
        chk(req, $sformatf("read 0x%0h", a), int'(reg_rdata), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Both-edge trial: hold line away from its level for g clocks under period p.
    task automatic trial(input int line, input int p, input int g);
        int  pe, w, lows, first, other;
        logic cur;
        pe = (p < 1) ? 1 : p;
        w  = 2 * pe + g + 6;
        wr(8'h9C, p);
        idle(2 * pe + 8);
        cur = line_in[line];
        line_in[line] = ~cur;
        lows = 0; first = -1; other = 0;
        for (int k = 1; k <= w; k++) begin
            @(negedge clk);
            if (!irq_out[line]) begin
                lows++;
                if (first < 0) first = k;
            end
            for (int j = 0; j < N; j++)
                if (j != line && !irq_out[j]) other++;
            if (k == g) line_in[line] = cur;
        end
        if (g >= pe) begin
            chk("R6", $sformatf("low cycles p=%0d g=%0d", p, g), lows, 2);
            chk("R6", $sformatf("first low p=%0d g=%0d", p, g), first, 2 + pe);
        end else begin
            chk("R5", $sformatf("glitch dropped p=%0d g=%0d", p, g), lows, 0);
        end
        chk("R9", $sformatf("other lines idle p=%0d g=%0d", p, g), other, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lows;
        total = 0; bad = 0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; line_in = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        rdchk(8'h90, 0, "R1");
        rdchk(8'h94, 0, "R1");
        rdchk(8'h98, 0, "R1");
        rdchk(8'h9C, 255, "R1");
        chk("R1", "irq after reset", int'(irq_out), 0);

        // R2: register map
        wr(8'h90, 32'hFFFF_FFFF);
        rdchk(8'h90, 15, "R2");
        wr(8'h9C, 32'h0000_1234);
        rdchk(8'h9C, 32'h34, "R2");
        wr(8'h80, 32'hFFFF_FFFF);
        rdchk(8'h80, 0, "R2");
        rdchk(8'h90, 15, "R2");
        rdchk(8'h94, 0, "R2");
        wr(8'h98, 32'h0000_0005);
        rdchk(8'h98, 5, "R2");
        wr(8'h98, 0);

        // R3: level mode latency
        idle(4);
        line_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3", "level after 2 edges", int'(irq_out[2]), 0);
        @(negedge clk);
        chk("R3", "level after 3 edges", int'(irq_out[2]), 1);
        chk("R3", "quiet line", int'(irq_out[0]), 0);

        // R4: mask in level mode
        wr(8'h90, 32'hB);
        @(negedge clk);
        chk("R4", "masked level line", int'(irq_out[2]), 0);
        wr(8'h90, 32'hF);
        idle(2);
        chk("R4", "unmasked again", int'(irq_out[2]), 1);

        // R10: level mode with filter
        wr(8'h9C, 3);
        wr(8'h98, 32'hF);
        idle(8);
        lows = 0;
        line_in[1] = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (irq_out[1]) lows++;
            if (k == 2) line_in[1] = 1'b0;
        end
        chk("R10", "short glitch in level mode", lows, 0);
        line_in[1] = 1'b1;
        idle(10);
        chk("R10", "held level accepted", int'(irq_out[1]), 1);

        // R7: both-edge without filter stays idle
        wr(8'h98, 0);
        wr(8'h94, 32'hF);
        idle(2);
        lows = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (!irq_out[3]) lows++;
            if (k % 4 == 0) line_in[3] = ~line_in[3];
        end
        chk("R7", "no pulses without filter", lows, 0);

        // R8: both-edge masked stays idle
        wr(8'h98, 32'hF);
        wr(8'h90, 0);
        lows = 0;
        line_in[0] = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (!irq_out[0]) lows++;
        end
        chk("R8", "masked both-edge line", lows, 0);

        // R5/R6/R9: sweep of period and excursion length
        wr(8'h90, 32'hF);
        idle(10);
        for (int p = 0; p <= 4; p++) begin
            for (int g = 1; g <= ((p < 1) ? 1 : p) + 1; g++)
                trial((p + g) % N, p, g);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule